// File: doc/BRIEF.md
# Core-Local Machine Timer

This block is a memory-mapped timer that sits next to a single processor core. It keeps a free-running 64-bit time count and a 64-bit compare value. Whenever the count has reached or passed the compare value, it holds the core's machine timer interrupt line high. Inside the core, that line sets bit 7 of the machine interrupt-pending register.

Software reaches the block through a plain 32-bit register port with an address, a write strobe, write data and combinational read data. Each 64-bit quantity is accessed as two 32-bit halves. The decoded window runs from offset 0x0000 to 0xBFFF and is sparsely populated. A placeholder software-interrupt register at offset 0x0000 has no function.

To program an interrupt, software writes the compare halves. To clear the interrupt, software moves the compare value ahead of the time count. The time count advances once per clock while the tick enable input is high.

Top module: `core_timer`

## Requirements
- R1: After reset the time count reads 0 in both halves, both compare halves read 0xFFFFFFFF, and the interrupt output is low.
- R2: In a clock where tick_en is high and no time half is written, the 64-bit time count increases by exactly one. In a clock where tick_en is low, it keeps its value.
- R3: The increment carries across the 64-bit value: a low half of 0xFFFFFFFF followed by one tick gives a low half of 0 and a high half increased by one.
- R4: Reads are combinational and take effect in the same cycle as the address. Offset 0x4000 returns compare bits 31:0, 0x4004 returns compare bits 63:32, 0xBFF8 returns time bits 31:0, and 0xBFFC returns time bits 63:32.
- R5: A write to one compare half replaces only that half. The other half keeps its value.
- R6: A write to one time half loads that half with the write data, and the other half keeps its value. In that clock the count does not increment, even when tick_en is high.
- R7: The interrupt output is a level. It is high exactly while the unsigned 64-bit time count is greater than or equal to the 64-bit compare value, equality included. It falls once the compare value is raised above the time count.
- R8: The software-interrupt register at offset 0x0000 always reads 0, and writes to it change no register.
- R9: Any other offset, whether inside the window up to 0xBFFF, not on a listed register, or above 0xBFFF, reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Advance the time count this clock |
| bus_addr | input | 16 | Byte offset within the timer window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| timer_irq | output | 1 | Machine timer interrupt level |

## Verification
The hardest situations to reach from the ports are the exact equality edge of the compare and a carry out of the low time half. The count would take billions of ticks to reach either one on its own. The stimulus instead loads the time halves directly to values a few ticks short of the target. It then releases tick_en for a counted number of clocks and samples the interrupt and both halves on the clocks just before, at and after the boundary.

// File: rtl/ctimer_pkg.sv
// Package: shared offsets and register-select type for the core-local timer.
// Assumes a byte-addressed window of at least 16 address bits.
package ctimer_pkg;

    localparam logic [15:0] OFS_SOFT    = 16'h0000;
    localparam logic [15:0] OFS_CMP_LO  = 16'h4000;
    localparam logic [15:0] OFS_CMP_HI  = 16'h4004;
    localparam logic [15:0] OFS_TIME_LO = 16'hBFF8;
    localparam logic [15:0] OFS_TIME_HI = 16'hBFFC;
    localparam logic [15:0] OFS_LAST    = 16'hBFFF;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SOFT,
        SEL_CMP_LO,
        SEL_CMP_HI,
        SEL_TIME_LO,
        SEL_TIME_HI
    } ctimer_sel_e;

endpackage

// File: rtl/ctimer_regdec.sv
// Module: address decoder for the timer window.
// Maps a byte offset to a register select. Offsets beyond the window, and
// offsets that match no register exactly, select nothing.
module ctimer_regdec
    import ctimer_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output ctimer_sel_e       sel
);

    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(OFS_LAST);

    // Decode the offset to one register, or to none.
    always_comb begin
        sel = SEL_NONE;
        if (addr <= LAST_A) begin
            if (addr == ADDR_W'(OFS_SOFT))         sel = SEL_SOFT;
            else if (addr == ADDR_W'(OFS_CMP_LO))  sel = SEL_CMP_LO;
            else if (addr == ADDR_W'(OFS_CMP_HI))  sel = SEL_CMP_HI;
            else if (addr == ADDR_W'(OFS_TIME_LO)) sel = SEL_TIME_LO;
            else if (addr == ADDR_W'(OFS_TIME_HI)) sel = SEL_TIME_HI;
        end
    end

endmodule

// File: rtl/ctimer_split_reg.sv
// Module: wide register written in equal-width slices, with optional increment.
// A slice write replaces only that slice and suppresses the increment for
// that clock. With COUNT set, the whole value increments when inc is high
// and no slice is written.
module ctimer_split_reg #(
    parameter int          HALF_W = 32,
    parameter int          NHALF  = 2,
    parameter bit          COUNT  = 1'b0,
    parameter logic [HALF_W*NHALF-1:0] RST_VAL = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      inc,
    input  logic [NHALF-1:0]          wr_half,
    input  logic [HALF_W-1:0]         wdata,
    output logic [HALF_W*NHALF-1:0]   value
);

    localparam int FULL_W = HALF_W * NHALF;

    logic [FULL_W-1:0] val_q;
    logic [FULL_W-1:0] val_d;
    logic [FULL_W-1:0] bumped;

    // Select the incremented or held value per the COUNT variant.
    generate
        if (COUNT) begin : g_count
            assign bumped = inc ? (val_q + FULL_W'(1)) : val_q;
        end else begin : g_hold
            assign bumped = val_q;
        end
    endgenerate

    // Replace written slices; otherwise take the bumped value.
    generate
        for (genvar h = 0; h < NHALF; h++) begin : g_half
            always_comb begin
                if (|wr_half)
                    val_d[h*HALF_W +: HALF_W] = wr_half[h] ? wdata
                                                           : val_q[h*HALF_W +: HALF_W];
                else
                    val_d[h*HALF_W +: HALF_W] = bumped[h*HALF_W +: HALF_W];
            end
        end
    endgenerate

    // Register state with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= RST_VAL;
        else        val_q <= val_d;
    end

    assign value = val_q;

endmodule

// File: rtl/ctimer_cmp.sv
// Module: unsigned magnitude compare giving the interrupt level.
// Assumes both operands are unsigned and of equal width.
module ctimer_cmp #(
    parameter int W = 64
) (
    input  logic [W-1:0] now_val,
    input  logic [W-1:0] limit_val,
    output logic         reached
);

    // High whenever the count has reached or passed the limit.
    always_comb reached = (now_val >= limit_val);

endmodule

// File: rtl/core_timer.sv
// Module: core-local machine timer, top level.
// Holds a 64-bit time count and a 64-bit compare value, both reachable as
// 32-bit halves, and drives a level interrupt while time >= compare.
// Assumes one outstanding access per clock and combinational read data.
module core_timer
    import ctimer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              timer_irq
);

    localparam int WIDE_W = 2 * DATA_W;

    ctimer_sel_e        sel;
    logic [1:0]         time_wr;
    logic [1:0]         cmp_wr;
    logic [WIDE_W-1:0]  time_q;
    logic [WIDE_W-1:0]  cmp_q;

    ctimer_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    // Turn the select and write strobe into per-half write enables.
    always_comb begin
        time_wr = 2'b00;
        cmp_wr  = 2'b00;
        if (bus_we) begin
            time_wr[0] = (sel == SEL_TIME_LO);
            time_wr[1] = (sel == SEL_TIME_HI);
            cmp_wr[0]  = (sel == SEL_CMP_LO);
            cmp_wr[1]  = (sel == SEL_CMP_HI);
        end
    end

    ctimer_split_reg #(
        .HALF_W (DATA_W),
        .NHALF  (2),
        .COUNT  (1'b1),
        .RST_VAL('0)
    ) u_time (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (tick_en),
        .wr_half(time_wr),
        .wdata  (bus_wdata),
        .value  (time_q)
    );

    ctimer_split_reg #(
        .HALF_W (DATA_W),
        .NHALF  (2),
        .COUNT  (1'b0),
        .RST_VAL('1)
    ) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (1'b0),
        .wr_half(cmp_wr),
        .wdata  (bus_wdata),
        .value  (cmp_q)
    );

    ctimer_cmp #(.W(WIDE_W)) u_ge (
        .now_val  (time_q),
        .limit_val(cmp_q),
        .reached  (timer_irq)
    );

    // Return the selected half; the placeholder and unmapped offsets read 0.
    always_comb begin
        unique case (sel)
            SEL_CMP_LO:  bus_rdata = cmp_q[DATA_W-1:0];
            SEL_CMP_HI:  bus_rdata = cmp_q[WIDE_W-1:DATA_W];
            SEL_TIME_LO: bus_rdata = time_q[DATA_W-1:0];
            SEL_TIME_HI: bus_rdata = time_q[WIDE_W-1:DATA_W];
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/core_timer_chk.sv
// Module: property checker for core_timer, attached by bind.
module core_timer_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_en,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                timer_irq,
    input logic [2*DATA_W-1:0] time_val,
    input logic [2*DATA_W-1:0] cmp_val
);

    localparam int WIDE_W = 2 * DATA_W;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (time_val == '0 && cmp_val == '1 && !timer_irq));

    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !bus_we) |=> (time_val == $past(time_val) + WIDE_W'(1)));

    // R5
    cmp_lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(16'h4000))
        |=> (cmp_val[WIDE_W-1:DATA_W] == $past(cmp_val[WIDE_W-1:DATA_W])));

    // R6
    time_lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(16'hBFF8))
        |=> (time_val[WIDE_W-1:DATA_W] == $past(time_val[WIDE_W-1:DATA_W])));

    // R7
    irq_below_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (time_val < cmp_val) |-> !timer_irq);

    // R8
    soft_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata == '0));

endmodule

bind core_timer core_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_rdata(bus_rdata),
    .timer_irq(timer_irq),
    .time_val (time_q),
    .cmp_val  (cmp_q)
);

// File: tb/core_timer_bench.sv
// Directed bench for core_timer: one task per scenario, each self-checking.
module core_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        timer_irq;

    int n_checks = 0;
    int n_fails  = 0;

    core_timer u_core_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .timer_irq(timer_irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        for (int i = 0; i < n; i++) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(16'hBFF8, v); check("R1 time lo", v, 32'h0);
        rd(16'hBFFC, v); check("R1 time hi", v, 32'h0);
        rd(16'h4000, v); check("R1 cmp lo", v, 32'hFFFF_FFFF);
        rd(16'h4004, v); check("R1 cmp hi", v, 32'hFFFF_FFFF);
        check("R1 irq", {31'b0, timer_irq}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(16'h0000, 32'h1);
        rd(16'h0000, v); check("R8 soft reads 0", v, 32'h0);
        wr(16'h1234, 32'hDEAD_BEEF);
        wr(16'hC000, 32'h1111_2222);
        wr(16'h4002, 32'h3333_4444);
        rd(16'h1234, v); check("R9 inner hole", v, 32'h0);
        rd(16'hC000, v); check("R9 above window", v, 32'h0);
        rd(16'hFFFC, v); check("R9 top of space", v, 32'h0);
        rd(16'h4002, v); check("R9 misaligned", v, 32'h0);
        rd(16'h4000, v); check("R8 R9 cmp lo intact", v, 32'hFFFF_FFFF);
        rd(16'h4004, v); check("R8 R9 cmp hi intact", v, 32'hFFFF_FFFF);
        rd(16'hBFF8, v); check("R8 R9 time lo intact", v, 32'h0);
        rd(16'hBFFC, v); check("R8 R9 time hi intact", v, 32'h0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        run_ticks(10);
        rd(16'hBFF8, v); check("R2 ten ticks", v, 32'd10);
        repeat (5) @(negedge clk);
        rd(16'hBFF8, v); check("R2 hold without enable", v, 32'd10);
    endtask

    task automatic t_carry();
        logic [31:0] v;
        wr(16'hBFF8, 32'hFFFF_FFFE);
        wr(16'hBFFC, 32'h0000_0005);
        run_ticks(3);
        rd(16'hBFF8, v); check("R3 lo wraps", v, 32'h0000_0001);
        rd(16'hBFFC, v); check("R3 hi carries", v, 32'h0000_0006);
    endtask

    task automatic t_time_half();
        logic [31:0] v;
        @(negedge clk);
        bus_addr = 16'hBFF8; bus_wdata = 32'h0000_0100; bus_we = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_en = 1'b0;
        rd(16'hBFF8, v); check("R6 lo loaded, no tick", v, 32'h0000_0100);
        rd(16'hBFFC, v); check("R6 hi kept", v, 32'h0000_0006);
        wr(16'hBFFC, 32'h0000_00AA);
        rd(16'hBFF8, v); check("R6 lo kept", v, 32'h0000_0100);
        rd(16'hBFFC, v); check("R4 R6 hi read", v, 32'h0000_00AA);
    endtask

    task automatic t_cmp_half();
        logic [31:0] v;
        wr(16'h4000, 32'h0000_1234);
        rd(16'h4004, v); check("R5 hi kept", v, 32'hFFFF_FFFF);
        rd(16'h4000, v); check("R4 cmp lo read", v, 32'h0000_1234);
        wr(16'h4004, 32'h0000_0007);
        rd(16'h4000, v); check("R5 lo kept", v, 32'h0000_1234);
        rd(16'h4004, v); check("R4 cmp hi read", v, 32'h0000_0007);
    endtask

    task automatic t_irq();
        // compare is 0x7_00001234
        wr(16'hBFFC, 32'h0000_0007);
        wr(16'hBFF8, 32'h0000_1230);
        #1 check("R7 below", {31'b0, timer_irq}, 32'h0);
        run_ticks(3);
        #1 check("R7 one short", {31'b0, timer_irq}, 32'h0);
        run_ticks(1);
        #1 check("R7 equal fires", {31'b0, timer_irq}, 32'h1);
        run_ticks(2);
        #1 check("R7 above stays", {31'b0, timer_irq}, 32'h1);
        wr(16'h4004, 32'h0000_0008);
        #1 check("R7 raised compare clears", {31'b0, timer_irq}, 32'h0);
        wr(16'h4004, 32'h0000_0006);
        wr(16'h4000, 32'hFFFF_FFFF);
        #1 check("R7 high half dominates", {31'b0, timer_irq}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unmapped();
        t_count();
        t_carry();
        t_time_half();
        t_cmp_half();
        t_irq();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule